// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This block sits between a clocked host and an external asynchronous static RAM of 131,072 words by 16 bits. The host posts one request at a time using a request/ready handshake. Each request carries a read/write flag, a 17-bit word address, 16 bits of write data and a two-bit byte mask. The controller turns each request into a fixed sequence of active-low memory strobes. Every phase of that sequence lasts a whole number of clock cycles, and the counts are set by module parameters. The parameters are chosen so that the memory's minimum cycle, pulse and setup times are met at the chosen clock rate.

The memory has one chip select, one write strobe, one output enable and one select line per byte lane. Each lane line is active low, and a lane takes part in an access only while its line is low. Every access goes through the states idle, setup, strobe and recover. In a write, the write strobe is asserted only while chip select and the chosen lanes are already low. Output enable stays high for the whole write. The controller drives the shared data bus only when output enable was already high in the previous cycle, so the memory and the controller never drive the bus in the same cycle. The pad buffers are outside this block; the controller provides only the outgoing data and its enable.

Top module: `sram_lane_ctrl`

## Requirements
- R1: While reset is high, and in the first cycle after it, chip select, write strobe and output enable are high, both lane selects are high, the data-bus enable is low and ready is low.
- R2: Host mask bit 0 selects the lower byte (data bits 7:0) and drives lane select bit 0 low. Mask bit 1 selects the upper byte (bits 15:8) and drives lane select bit 1 low. A write changes only the selected bytes of the addressed word.
- R3: A request with mask 00 still completes with a ready pulse. Chip select, both lane selects, the write strobe and output enable stay high throughout, so the word in memory is unchanged.
- R4: In a write, the address, the outgoing data and the data-bus enable are presented SETUP_CYC cycles before the write strobe falls. The strobe then stays low for exactly WR_STROBE_CYC cycles. Chip select, the lane selects and the address do not change while the strobe is low.
- R5: Output enable is high throughout every write. The data-bus enable is high only during writes, and only in a cycle whose previous cycle also had output enable high.
- R6: In a read, output enable stays low for exactly RD_STROBE_CYC cycles while the write strobe is high. The read data is captured in the last of those cycles. Bytes that the mask does not select read as zero.
- R7: For each accepted request, ready is high for exactly one cycle. Ready rises SETUP_CYC + strobe count + RECOVER_CYC cycles after the clock edge that accepted the request, where the strobe count is WR_STROBE_CYC for writes and RD_STROBE_CYC for reads. On a read, the read data is valid while ready is high.
- R8: A request is accepted only when the controller is idle. A request raised while an access is in progress causes no memory access and no ready pulse.
- R9: All 17 address bits reach the memory address pins, including the lowest address (0x00000) and the highest address (0x1FFFF).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | Request strobe, sampled only when idle |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 17 | Word address |
| host_wdata | input | 16 | Write data |
| host_mask | input | 2 | Byte enables, bit 0 lower, bit 1 upper |
| host_ready | output | 1 | One-cycle completion pulse |
| host_rdata | output | 16 | Read data, unselected bytes zero |
| mem_addr | output | 17 | Memory address pins |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_lane_n | output | 2 | Lane selects, bit 0 lower byte, active low |
| mem_dq_out | output | 16 | Data toward the memory |
| mem_dq_oe | output | 1 | Enable for the outgoing data on the shared bus |
| mem_dq_in | input | 16 | Data from the memory |

## Verification
All outputs are registered. The memory pins therefore change in the cycle after the edge that accepts a request. Ready rises exactly setup plus strobe plus recover cycles after that edge, which is 11 cycles for a write and 13 cycles for a read with the default parameters. The bench samples on falling edges. It counts cycles from the falling edge that follows the accepting edge and requires ready at exactly that count, with the read data compared in the same cycle. The bench's memory model checks each write strobe on every falling edge for its length, a stable address and data, the data setup it received, and output enable staying high, then stores the bytes when the strobe rises. Reads return the model's contents within the strobe window, so each byte-masked read-back also shows whether earlier partial writes left the other byte alone.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_SETUP   = 2'd1,
    ST_STROBE  = 2'd2,
    ST_RECOVER = 2'd3
  } ctrl_state_t;
endpackage

// File: rtl/sram_cycle_timer.sv
// Down counter timing one phase of an access; last is high in the phase's final cycle.
module sram_cycle_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             last
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign last = (cnt == '0);
endmodule

// File: rtl/sram_lane_map.sv
// Maps a byte mask onto active-low lane selects and zeroes unselected read bytes.
module sram_lane_map #(
  parameter int DATA_W = 16,
  localparam int LANES = DATA_W / 8
) (
  input  logic [LANES-1:0]  mask,
  input  logic [DATA_W-1:0] raw,
  output logic [LANES-1:0]  lane_n,
  output logic [DATA_W-1:0] masked
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane_n[i]         = ~mask[i];
    assign masked[i*8 +: 8]  = mask[i] ? raw[i*8 +: 8] : 8'h00;
  end
endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl #(
  parameter int ADDR_W        = 17,
  parameter int DATA_W        = 16,
  parameter int SETUP_CYC     = 1,
  parameter int WR_STROBE_CYC = 9,
  parameter int RD_STROBE_CYC = 11,
  parameter int RECOVER_CYC   = 1,
  localparam int LANES   = DATA_W / 8,
  localparam int MAX_CYC = (WR_STROBE_CYC > RD_STROBE_CYC) ? WR_STROBE_CYC : RD_STROBE_CYC,
  localparam int ALL_MAX = (MAX_CYC > SETUP_CYC) ? ((MAX_CYC > RECOVER_CYC) ? MAX_CYC : RECOVER_CYC)
                                                 : ((SETUP_CYC > RECOVER_CYC) ? SETUP_CYC : RECOVER_CYC),
  localparam int CNT_W   = $clog2(ALL_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_req,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic [LANES-1:0]  host_mask,
  output logic              host_ready,
  output logic [DATA_W-1:0] host_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [LANES-1:0]  mem_lane_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);
  import sram_ctrl_pkg::*;

  ctrl_state_t      state, nxt;
  logic             wr_q;
  logic [LANES-1:0] mask_q;
  logic             cur_wr;
  logic [LANES-1:0] cur_mask;
  logic             cur_any;
  logic             t_load, t_last;
  logic [CNT_W-1:0] t_val;
  logic [LANES-1:0] lane_n_map;
  logic [DATA_W-1:0] rd_masked;

  // In idle the incoming request defines the access; afterwards the latched copy does.
  assign cur_wr   = (state == ST_IDLE) ? host_we   : wr_q;
  assign cur_mask = (state == ST_IDLE) ? host_mask : mask_q;
  assign cur_any  = |cur_mask;

  sram_cycle_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .load(t_load), .load_val(t_val), .last(t_last)
  );

  sram_lane_map #(.DATA_W(DATA_W)) u_lanes (
    .mask(cur_mask), .raw(mem_dq_in), .lane_n(lane_n_map), .masked(rd_masked)
  );

  always_comb begin
    nxt    = state;
    t_load = 1'b0;
    t_val  = '0;
    unique case (state)
      ST_IDLE: if (host_req) begin
        nxt = ST_SETUP; t_load = 1'b1; t_val = CNT_W'(SETUP_CYC - 1);
      end
      ST_SETUP: if (t_last) begin
        nxt = ST_STROBE; t_load = 1'b1;
        t_val = wr_q ? CNT_W'(WR_STROBE_CYC - 1) : CNT_W'(RD_STROBE_CYC - 1);
      end
      ST_STROBE: if (t_last) begin
        nxt = ST_RECOVER; t_load = 1'b1; t_val = CNT_W'(RECOVER_CYC - 1);
      end
      ST_RECOVER: if (t_last) nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      wr_q       <= 1'b0;
      mask_q     <= '0;
      host_ready <= 1'b0;
      host_rdata <= '0;
      mem_addr   <= '0;
      mem_cs_n   <= 1'b1;
      mem_we_n   <= 1'b1;
      mem_oe_n   <= 1'b1;
      mem_lane_n <= '1;
      mem_dq_out <= '0;
      mem_dq_oe  <= 1'b0;
    end else begin
      state      <= nxt;
      host_ready <= (state == ST_RECOVER) && t_last;
      if (state == ST_IDLE && host_req) begin
        wr_q       <= host_we;
        mask_q     <= host_mask;
        mem_addr   <= host_addr;
        mem_dq_out <= host_wdata;
      end
      if (state == ST_STROBE && t_last && !wr_q)
        host_rdata <= rd_masked;
      mem_cs_n   <= !(nxt != ST_IDLE && cur_any);
      mem_lane_n <= (nxt != ST_IDLE) ? lane_n_map : '1;
      mem_we_n   <= !(nxt == ST_STROBE && cur_wr && cur_any);
      mem_oe_n   <= !(nxt == ST_STROBE && !cur_wr && cur_any);
      mem_dq_oe  <= (nxt != ST_IDLE) && cur_wr;
    end
  end
endmodule

// File: rtl/sram_ctrl_checker.sv
module sram_ctrl_checker (
  input logic       clk,
  input logic       rst,
  input logic       host_ready,
  input logic [16:0] mem_addr,
  input logic       mem_cs_n,
  input logic       mem_we_n,
  input logic       mem_oe_n,
  input logic [1:0] mem_lane_n,
  input logic [15:0] mem_dq_out,
  input logic       mem_dq_oe
);
  // R5: no write strobe while the memory is enabled onto the bus
  p_we_oe_excl_r5: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> mem_oe_n);
  // R5: controller drives the bus only after a cycle of output enable high
  p_dq_turn_r5: assert property (@(posedge clk) disable iff (rst)
    mem_dq_oe |-> (mem_oe_n && $past(mem_oe_n)));
  // R4: address and data hold while the strobe stays low
  p_addr_stable_r4: assert property (@(posedge clk) disable iff (rst)
    (!mem_we_n && $past(!mem_we_n)) |-> ($stable(mem_addr) && $stable(mem_dq_out) && $stable(mem_lane_n)));
  // R4: strobe falls only after the chip and lanes are already selected and data driven
  p_we_fall_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_we_n) |-> ($past(!mem_cs_n) && mem_dq_oe && $past(mem_dq_oe)));
  // R3: a deselected chip sees no strobe at all
  p_deselect_r3: assert property (@(posedge clk) disable iff (rst)
    (mem_cs_n || mem_lane_n == 2'b11) |-> (mem_we_n && mem_oe_n));
  // R7: ready lasts a single cycle
  p_ready_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    host_ready |=> !host_ready);
endmodule

bind sram_lane_ctrl sram_ctrl_checker u_chk (.*);

// File: tb/sim_sram_lane_ctrl.sv
`timescale 1ns/1ps
module sim_sram_lane_ctrl;
  localparam int S_C = 1, W_C = 9, R_C = 11, REC_C = 1;

  logic clk = 1'b0, rst = 1'b1;
  logic host_req = 0, host_we = 0;
  logic [16:0] host_addr = '0;
  logic [15:0] host_wdata = '0;
  logic [1:0]  host_mask = '0;
  logic host_ready;
  logic [15:0] host_rdata;
  logic [16:0] mem_addr;
  logic mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [1:0] mem_lane_n;
  logic [15:0] mem_dq_out;
  logic [15:0] mem_dq_in = 16'hA5A5;

  int checks = 0, errors = 0;
  bit done = 0;
  int writes_done = 0;
  bit cs_seen = 0;

  logic [15:0] ref_mem [int];
  logic [15:0] model_mem [int];

  always #2.5 clk = ~clk;

  sram_lane_ctrl u0 (.*);

  function automatic logic [15:0] init_val(input logic [16:0] a);
    return a[15:0] ^ 16'h5A3C ^ {15'd0, a[16]};
  endfunction
  function automatic logic [15:0] merge(input logic [15:0] old, input logic [15:0] nw, input logic [1:0] m);
    return {m[1] ? nw[15:8] : old[15:8], m[0] ? nw[7:0] : old[7:0]};
  endfunction
  function automatic logic [15:0] lane_zero(input logic [15:0] d, input logic [1:0] m);
    return {m[1] ? d[15:8] : 8'h00, m[0] ? d[7:0] : 8'h00};
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, got, exp);
    end
  endtask

  // Behavioural memory model, sampled on falling edges
  bit in_wr = 0; int wr_len = 0; logic [16:0] wr_a; logic [15:0] wr_d; logic [1:0] wr_l;
  bit prev_oe_n = 1;
  always @(negedge clk) begin
    if (!rst) begin
      if (!mem_cs_n) cs_seen = 1;
      if (mem_dq_oe && !prev_oe_n) chk("R5 bus drive after output enable", 0, 1);
      if (!mem_we_n) begin
        if (!in_wr) begin
          in_wr = 1; wr_len = 1; wr_a = mem_addr; wr_d = mem_dq_out; wr_l = mem_lane_n;
          if (!mem_dq_oe || mem_cs_n || !mem_oe_n) chk("R4 strobe start conditions", 0, 1);
        end else begin
          wr_len++;
          if (mem_addr !== wr_a || mem_dq_out !== wr_d || mem_lane_n !== wr_l)
            chk("R4 address or data moved during strobe", {mem_addr, mem_dq_out[14:0]}, {wr_a, wr_d[14:0]});
          if (!mem_oe_n) chk("R5 output enable during write", mem_oe_n, 1);
        end
      end else if (in_wr) begin
        in_wr = 0;
        chk("R4 write pulse length", wr_len, W_C);
        begin
          logic [15:0] old;
          old = model_mem.exists(int'(wr_a)) ? model_mem[int'(wr_a)] : init_val(wr_a);
          model_mem[int'(wr_a)] = merge(old, wr_d, ~wr_l);
        end
        writes_done++;
      end
      if (!mem_cs_n && mem_we_n && !mem_oe_n) begin
        logic [15:0] w;
        w = model_mem.exists(int'(mem_addr)) ? model_mem[int'(mem_addr)] : init_val(mem_addr);
        mem_dq_in = {mem_lane_n[1] ? 8'hEE : w[15:8], mem_lane_n[0] ? 8'hEE : w[7:0]};
      end else mem_dq_in = 16'hA5A5;
      prev_oe_n = mem_oe_n;
    end
  end

  task automatic access(input bit we, input logic [16:0] a, input logic [15:0] d,
                        input logic [1:0] m, input bit poke_busy, output logic [15:0] rd);
    int cnt;
    @(negedge clk);
    host_req = 1; host_we = we; host_addr = a; host_wdata = d; host_mask = m;
    @(negedge clk);
    host_req = 0; cs_seen = 0; cnt = 0;
    while (!host_ready && cnt < 100) begin
      @(negedge clk); cnt++;
      if (poke_busy && cnt == 3) begin
        host_req = 1; host_we = 1; host_addr = a ^ 17'h1; host_wdata = ~d; host_mask = 2'b11;
      end else host_req = 0;
    end
    chk(we ? "R7 write latency" : "R7 read latency", cnt, S_C + (we ? W_C : R_C) + REC_C);
    rd = host_rdata;
    if (we) begin
      logic [15:0] old;
      old = ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : init_val(a);
      ref_mem[int'(a)] = merge(old, d, m);
    end
  endtask

  task automatic read_cmp(input string req, input logic [16:0] a, input logic [1:0] m);
    logic [15:0] rd, e;
    access(0, a, 16'h0, m, 0, rd);
    e = ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : init_val(a);
    chk(req, rd, lane_zero(e, m));
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] rd;
    int wbefore;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 reset strobes", {mem_cs_n, mem_we_n, mem_oe_n, mem_lane_n, mem_dq_oe, host_ready}, 7'b1111100);
    rst = 0;
    @(negedge clk);
    chk("R1 first cycle after reset", {mem_cs_n, mem_we_n, mem_oe_n, mem_lane_n, mem_dq_oe, host_ready}, 7'b1111100);

    // R9 address extremes, R2 full word
    access(1, 17'h00000, 16'hBEEF, 2'b11, 0, rd);
    access(1, 17'h1FFFF, 16'hC0DE, 2'b11, 0, rd);
    read_cmp("R9 lowest address", 17'h00000, 2'b11);
    read_cmp("R9 highest address", 17'h1FFFF, 2'b11);
    chk("R9 address pins", mem_addr, 17'h1FFFF);

    // R2 lower-only then upper-only writes
    access(1, 17'h00123, 16'h1111, 2'b11, 0, rd);
    access(1, 17'h00123, 16'hAA55, 2'b01, 0, rd);
    read_cmp("R2 lower byte write", 17'h00123, 2'b11);
    access(1, 17'h00123, 16'h77CC, 2'b10, 0, rd);
    read_cmp("R2 upper byte write", 17'h00123, 2'b11);

    // R6 single-lane reads zero the other byte
    read_cmp("R6 lower-only read", 17'h00123, 2'b01);
    read_cmp("R6 upper-only read", 17'h00123, 2'b10);

    // R3 mask 00 write does nothing
    wbefore = writes_done;
    access(1, 17'h00123, 16'h0000, 2'b00, 0, rd);
    chk("R3 chip select held high", cs_seen, 0);
    chk("R3 no strobe", writes_done, wbefore);
    read_cmp("R3 word unchanged", 17'h00123, 2'b11);

    // R8 request while busy ignored
    wbefore = writes_done;
    access(1, 17'h00400, 16'h3C3C, 2'b11, 1, rd);
    host_req = 0;
    repeat (20) begin
      @(negedge clk);
      if (host_ready) chk("R8 no extra ready", 1, 0);
    end
    chk("R8 single write", writes_done, wbefore + 1);
    read_cmp("R8 neighbour untouched", 17'h00401, 2'b11);
    read_cmp("R8 target written", 17'h00400, 2'b11);

    // Random mix over a small address window
    for (int i = 0; i < 300; i++) begin
      logic [16:0] a;
      logic [1:0] m;
      a = {$urandom_range(1, 0) ? 4'hF : 4'h0, 9'd0, 4'($urandom_range(15, 0))};
      m = 2'($urandom_range(3, 0));
      if ($urandom_range(1, 0)) access(1, a, 16'($urandom), m, 0, rd);
      else read_cmp("R6 random read-back", a, m);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule